// File: doc/BRIEF.md
# Variable Block Size SAD Engine

This block scores one 16x16 current block against a stream of candidate reference blocks, one pixel row per cycle. For every candidate it finds the sum of absolute differences (SAD) for all sixteen 4x4 sub-blocks, all four 8x8 quadrants and the whole 16x16 block in a single pass over the rows. It keeps, for each of these 21 partitions, the lowest cost seen so far in the current search and the motion vector of the candidate that produced it.

A per-pixel object mask travels with each row. Pixels outside the video object drop out of every sum, so object-shaped regions can be matched without stray background pixels adding to the cost.

A search opens with a start strobe that resets every stored best. The search window and the candidate order are set by whatever feeds the rows, for example every displacement from -32 to +32 in both directions. The last candidate is tagged, and a done pulse follows once its costs have been compared.

Top module: `vbs_sad_engine`

## Requirements
- R1: A candidate is 16 rows. Row 0 is the `row_valid` cycle in which `cand_start` is high. Rows 1 to 15 are the following `row_valid` cycles, and idle cycles between rows are allowed. Column c of a row occupies bits [8c+7:8c] of `cur_row`/`ref_row` and bit c of `mask_row`. Pixels are 8-bit unsigned.
- R2: The cost of 4x4 partition b = 4*by + bx is the masked SAD over rows 4by..4by+3 and columns 4bx..4bx+3. Its best cost is reported as 12 bits at `best4_cost[12b+11:12b]`.
- R3: From the same rows, the cost of 8x8 partition q = 2*qy + qx covers rows 8qy..8qy+7 and columns 8qx..8qx+7. It is reported as 14 bits at `best8_cost[14q+13:14q]`. The 16x16 cost covers the whole block and is reported as 16 bits on `best16_cost`.
- R4: A pixel whose `mask_row` bit is 0 adds zero to every partition cost. A pixel whose bit is 1 adds |cur - ref|.
- R5: A partition's best cost and best vector are replaced only when the new cost is strictly smaller. On equal cost the earlier candidate's vector is kept.
- R6: After reset, and in the cycle after `search_start`, every best cost is all ones (0xFFF, 0x3FFF, 0xFFFF) and every best vector is zero.
- R7: `done` is high for exactly one cycle: the cycle after the fourth rising edge counting from the edge that samples row 15 of the candidate flagged by `cand_last`.
- R8: Candidates may follow each other with no idle cycle, and each is still scored on its own rows.
- R9: Vector components are 7-bit two's complement. They are sampled with `cand_start` and reported unchanged (`best4_mvx[7b+6:7b]`, and the same layout for the other vector fields).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| search_start | input | 1 | Clears all stored best results |
| cand_start | input | 1 | Marks row 0 of a candidate |
| cand_last | input | 1 | With cand_start: this candidate ends the search |
| cand_mvx | input | 7 | Horizontal displacement of the candidate |
| cand_mvy | input | 7 | Vertical displacement of the candidate |
| row_valid | input | 1 | A row is present on the row inputs |
| cur_row | input | 128 | 16 current-block pixels |
| ref_row | input | 128 | 16 reference pixels |
| mask_row | input | 16 | 1 = pixel inside object |
| done | output | 1 | Search finished pulse |
| best4_cost | output | 192 | Best 4x4 costs |
| best4_mvx | output | 112 | Best 4x4 horizontal vectors |
| best4_mvy | output | 112 | Best 4x4 vertical vectors |
| best8_cost | output | 56 | Best 8x8 costs |
| best8_mvx | output | 28 | Best 8x8 horizontal vectors |
| best8_mvy | output | 28 | Best 8x8 vertical vectors |
| best16_cost | output | 16 | Best 16x16 cost |
| best16_mvx | output | 7 | Best 16x16 horizontal vector |
| best16_mvy | output | 7 | Best 16x16 vertical vector |

## Verification
The bench drives candidates with the pixel data at its extremes (255 against 0 with every pixel counted), so every sum reaches its full width. A design with a narrow accumulator would wrap and report small costs. It fully masks a block so that all costs tie at zero. It also draws reference blocks from a small pool so that equal costs recur often. A compare written as less-or-equal would then report the later vector. Random row gaps, back-to-back candidates and sparse masks catch a row counter that advances on idle cycles, a pipeline that mixes one candidate's sums into the next, and a mask applied to only some partition levels. The exact cycle of the done pulse is checked, so an extra or missing pipeline stage shows up.

// File: rtl/vbs_sad_engine.sv
module vbs_sad_engine #(
  parameter int PW  = 8,
  parameter int MVW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 search_start,
  input  logic                 cand_start,
  input  logic                 cand_last,
  input  logic [MVW-1:0]       cand_mvx,
  input  logic [MVW-1:0]       cand_mvy,
  input  logic                 row_valid,
  input  logic [16*PW-1:0]     cur_row,
  input  logic [16*PW-1:0]     ref_row,
  input  logic [15:0]          mask_row,
  output logic                 done,
  output logic [16*(PW+4)-1:0] best4_cost,
  output logic [16*MVW-1:0]    best4_mvx,
  output logic [16*MVW-1:0]    best4_mvy,
  output logic [4*(PW+6)-1:0]  best8_cost,
  output logic [4*MVW-1:0]     best8_mvx,
  output logic [4*MVW-1:0]     best8_mvy,
  output logic [PW+7:0]        best16_cost,
  output logic [MVW-1:0]       best16_mvx,
  output logic [MVW-1:0]       best16_mvy
);
  localparam int W4  = PW + 4;
  localparam int W8  = PW + 6;
  localparam int W16 = PW + 8;
  localparam int WB  = PW + 2;

  logic [3:0] row_cnt;
  logic [3:0] idx;
  assign idx = cand_start ? 4'd0 : row_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) row_cnt <= '0;
    else if (row_valid) row_cnt <= idx + 4'd1;

  logic [PW-1:0] ad [16];
  logic [WB-1:0] band [4];

  for (genvar c = 0; c < 16; c++) begin : g_col
    logic [PW-1:0] a, b;
    assign a = cur_row[c*PW +: PW];
    assign b = ref_row[c*PW +: PW];
    assign ad[c] = !mask_row[c] ? '0 : (a > b) ? a - b : b - a;
  end

  for (genvar k = 0; k < 4; k++) begin : g_band
    assign band[k] = WB'(ad[4*k]) + WB'(ad[4*k+1]) + WB'(ad[4*k+2]) + WB'(ad[4*k+3]);
  end

  logic [W4-1:0] acc [16];

  for (genvar g = 0; g < 16; g++) begin : g_acc
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) acc[g] <= '0;
      else if (row_valid && idx[3:2] == 2'(g / 4))
        acc[g] <= (idx[1:0] == 2'd0 ? '0 : acc[g]) + W4'(band[g % 4]);
  end

  logic [MVW-1:0] cmvx, cmvy;
  logic           clast, fin_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmvx  <= '0;
      cmvy  <= '0;
      clast <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      if (row_valid && cand_start) begin
        cmvx  <= cand_mvx;
        cmvy  <= cand_mvy;
        clast <= cand_last;
      end
      fin_q <= row_valid && idx == 4'd15;
    end

  logic [W8-1:0]  t8 [4];
  logic [W16-1:0] t16;

  for (genvar q = 0; q < 4; q++) begin : g_tree8
    localparam int B0 = (q / 2) * 8 + (q % 2) * 2;
    assign t8[q] = W8'(acc[B0]) + W8'(acc[B0+1]) + W8'(acc[B0+4]) + W8'(acc[B0+5]);
  end
  assign t16 = W16'(t8[0]) + W16'(t8[1]) + W16'(t8[2]) + W16'(t8[3]);

  logic [W4-1:0]  s4 [16];
  logic [W8-1:0]  s8 [4];
  logic [W16-1:0] s16;
  logic [MVW-1:0] smvx, smvy;
  logic           st_vld, st_last;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_vld  <= 1'b0;
      st_last <= 1'b0;
      smvx    <= '0;
      smvy    <= '0;
      s16     <= '0;
    end else begin
      st_vld  <= fin_q;
      st_last <= fin_q && clast;
      if (fin_q) begin
        smvx <= cmvx;
        smvy <= cmvy;
        s16  <= t16;
      end
    end

  for (genvar g = 0; g < 16; g++) begin : g_st4
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) s4[g] <= '0;
      else if (fin_q) s4[g] <= acc[g];
  end

  for (genvar q = 0; q < 4; q++) begin : g_st8
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) s8[q] <= '0;
      else if (fin_q) s8[q] <= t8[q];
  end

  logic [W4-1:0]  b4c [16];
  logic [MVW-1:0] b4x [16], b4y [16];
  logic [W8-1:0]  b8c [4];
  logic [MVW-1:0] b8x [4], b8y [4];
  logic [W16-1:0] b16c;
  logic [MVW-1:0] b16x, b16y;

  for (genvar g = 0; g < 16; g++) begin : g_best4
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        b4c[g] <= '1;
        b4x[g] <= '0;
        b4y[g] <= '0;
      end else if (search_start) begin
        b4c[g] <= '1;
        b4x[g] <= '0;
        b4y[g] <= '0;
      end else if (st_vld && s4[g] < b4c[g]) begin
        b4c[g] <= s4[g];
        b4x[g] <= smvx;
        b4y[g] <= smvy;
      end
    assign best4_cost[g*W4 +: W4]  = b4c[g];
    assign best4_mvx[g*MVW +: MVW] = b4x[g];
    assign best4_mvy[g*MVW +: MVW] = b4y[g];

    a_r5_best4_nonincr: assert property (@(posedge clk) disable iff (!rst_n)
      !search_start |=> b4c[g] <= $past(b4c[g]));
    a_r5_best4_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (!search_start && !(st_vld && s4[g] < b4c[g])) |=>
        ($stable(b4c[g]) && $stable(b4x[g]) && $stable(b4y[g])));
  end

  for (genvar q = 0; q < 4; q++) begin : g_best8
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        b8c[q] <= '1;
        b8x[q] <= '0;
        b8y[q] <= '0;
      end else if (search_start) begin
        b8c[q] <= '1;
        b8x[q] <= '0;
        b8y[q] <= '0;
      end else if (st_vld && s8[q] < b8c[q]) begin
        b8c[q] <= s8[q];
        b8x[q] <= smvx;
        b8y[q] <= smvy;
      end
    assign best8_cost[q*W8 +: W8]  = b8c[q];
    assign best8_mvx[q*MVW +: MVW] = b8x[q];
    assign best8_mvy[q*MVW +: MVW] = b8y[q];

    a_r5_best8_nonincr: assert property (@(posedge clk) disable iff (!rst_n)
      !search_start |=> b8c[q] <= $past(b8c[q]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      b16c <= '1;
      b16x <= '0;
      b16y <= '0;
    end else if (search_start) begin
      b16c <= '1;
      b16x <= '0;
      b16y <= '0;
    end else if (st_vld && s16 < b16c) begin
      b16c <= s16;
      b16x <= smvx;
      b16y <= smvy;
    end
  assign best16_cost = b16c;
  assign best16_mvx  = b16x;
  assign best16_mvy  = b16y;

  logic cmp_last;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_last <= 1'b0;
      done     <= 1'b0;
    end else begin
      cmp_last <= st_vld && st_last;
      done     <= cmp_last;
    end

  a_r6_init_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    search_start |=> (b16c == '1 && b16x == '0 && b16y == '0));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(cmp_last));
  a_r1_start_with_row: assert property (@(posedge clk) disable iff (!rst_n)
    cand_start |-> row_valid);
  a_r8_stage_follows_row15: assert property (@(posedge clk) disable iff (!rst_n)
    st_vld |-> $past(fin_q));

endmodule

// File: tb/tb_vbs_sad_engine.sv
module tb_vbs_sad_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic search_start = 1'b0, cand_start = 1'b0, cand_last = 1'b0, row_valid = 1'b0;
  logic [6:0] cand_mvx = '0, cand_mvy = '0;
  logic [127:0] cur_row = '0, ref_row = '0;
  logic [15:0] mask_row = '0;
  logic done;
  logic [191:0] best4_cost;
  logic [111:0] best4_mvx, best4_mvy;
  logic [55:0] best8_cost;
  logic [27:0] best8_mvx, best8_mvy;
  logic [15:0] best16_cost;
  logic [6:0] best16_mvx, best16_mvy;

  always #5 clk = ~clk;

  vbs_sad_engine dut (.*);

  int tests = 0, fails = 0;
  logic [7:0] cur [16][16];
  logic [7:0] pool [4][16][16];
  logic msk [16][16];
  int e4c [16], e8c [4], e16c;
  logic [6:0] e4x [16], e4y [16], e8x [4], e8y [4], e16x, e16y;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sad(int pi, int y0, int x0, int n);
    int s = 0;
    for (int y = y0; y < y0 + n; y++)
      for (int x = x0; x < x0 + n; x++)
        if (msk[y][x]) s += (cur[y][x] > pool[pi][y][x]) ? cur[y][x] - pool[pi][y][x]
                                                          : pool[pi][y][x] - cur[y][x];
    return s;
  endfunction

  task automatic fill(int mode);
    for (int y = 0; y < 16; y++)
      for (int x = 0; x < 16; x++) begin
        cur[y][x] = (mode == 1) ? 8'd255 : 8'($urandom);
        for (int p = 0; p < 4; p++) pool[p][y][x] = (mode == 1) ? 8'd0 : 8'($urandom);
        case (mode)
          1: msk[y][x] = 1'b1;
          2: msk[y][x] = 1'b0;
          3: msk[y][x] = ($urandom_range(0, 3) == 0);
          default: msk[y][x] = ($urandom_range(0, 7) != 0);
        endcase
      end
  endtask

  task automatic run_search(int mode, int ncand, int gaps, int corners);
    int pi, c;
    logic [6:0] vx, vy;
    fill(mode);
    for (int i = 0; i < 16; i++) begin e4c[i] = 4095; e4x[i] = 0; e4y[i] = 0; end
    for (int i = 0; i < 4; i++) begin e8c[i] = 16383; e8x[i] = 0; e8y[i] = 0; end
    e16c = 65535; e16x = 0; e16y = 0;
    @(negedge clk); search_start = 1'b1;
    @(negedge clk); search_start = 1'b0;
    for (int k = 0; k < ncand; k++) begin
      pi = $urandom_range(0, 3);
      if (corners) begin
        vx = 7'((k % 3) * 32 - 32);
        vy = 7'((k / 3) * 32 - 32);
      end else begin
        vx = 7'($urandom_range(0, 64) - 32);
        vy = 7'($urandom_range(0, 64) - 32);
      end
      for (int b = 0; b < 16; b++) begin
        c = sad(pi, (b / 4) * 4, (b % 4) * 4, 4);
        if (c < e4c[b]) begin e4c[b] = c; e4x[b] = vx; e4y[b] = vy; end
      end
      for (int q = 0; q < 4; q++) begin
        c = sad(pi, (q / 2) * 8, (q % 2) * 8, 8);
        if (c < e8c[q]) begin e8c[q] = c; e8x[q] = vx; e8y[q] = vy; end
      end
      c = sad(pi, 0, 0, 16);
      if (c < e16c) begin e16c = c; e16x = vx; e16y = vy; end
      for (int r = 0; r < 16; r++) begin
        if (gaps) repeat ($urandom_range(0, 2)) begin
          @(negedge clk);
          row_valid = 1'b0; cand_start = 1'b0;
          cur_row = {128{1'b1}}; ref_row = '0; mask_row = '1;
        end
        @(negedge clk);
        row_valid = 1'b1;
        cand_start = (r == 0);
        cand_last = (r == 0) && (k == ncand - 1);
        cand_mvx = (r == 0) ? vx : 7'h55;
        cand_mvy = (r == 0) ? vy : 7'h2a;
        for (int x = 0; x < 16; x++) begin
          cur_row[x*8 +: 8] = cur[r][x];
          ref_row[x*8 +: 8] = pool[pi][r][x];
          mask_row[x] = msk[r][x];
        end
      end
    end
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 1) begin row_valid = 1'b0; cand_start = 1'b0; cand_last = 1'b0; end
      chk("R7 done timing", int'(done), (k == 4) ? 1 : 0);
    end
    for (int b = 0; b < 16; b++) begin
      chk("R2 R4 R5 4x4 cost", int'(best4_cost[b*12 +: 12]), e4c[b]);
      chk("R5 R9 4x4 mvx", int'(best4_mvx[b*7 +: 7]), int'(e4x[b]));
      chk("R5 R9 4x4 mvy", int'(best4_mvy[b*7 +: 7]), int'(e4y[b]));
    end
    for (int q = 0; q < 4; q++) begin
      chk("R3 R4 R5 8x8 cost", int'(best8_cost[q*14 +: 14]), e8c[q]);
      chk("R3 R9 8x8 mvx", int'(best8_mvx[q*7 +: 7]), int'(e8x[q]));
      chk("R3 R9 8x8 mvy", int'(best8_mvy[q*7 +: 7]), int'(e8y[q]));
    end
    chk("R3 R8 16x16 cost", int'(best16_cost), e16c);
    chk("R3 R9 16x16 mvx", int'(best16_mvx), int'(e16x));
    chk("R3 R9 16x16 mvy", int'(best16_mvy), int'(e16y));
  endtask

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog R7 actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset done", int'(done), 0);
    chk("R6 reset 4x4 cost", int'(best4_cost[11:0]), 4095);
    chk("R6 reset 8x8 cost", int'(best8_cost[55:42]), 16383);
    chk("R6 reset 16x16 cost", int'(best16_cost), 65535);
    chk("R6 reset 16x16 mvx", int'(best16_mvx), 0);
    run_search(1, 3, 0, 0);
    run_search(2, 4, 1, 0);
    run_search(0, 40, 1, 0);
    run_search(3, 40, 0, 0);
    run_search(0, 9, 0, 1);
    @(negedge clk); search_start = 1'b1;
    @(negedge clk); search_start = 1'b0;
    chk("R6 restart 4x4 cost", int'(best4_cost[191:180]), 4095);
    chk("R6 restart 8x8 mvy", int'(best8_mvy[6:0]), 0);
    chk("R6 restart 16x16 cost", int'(best16_cost), 65535);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule